// File: doc/BRIEF.md
# Serial Control Register File for a Stereo DAC

This block is the control front end of a stereo audio converter. An external host sends 16-bit control words over a four-wire serial link made of a clock, an active-low select, a data line and a return line, with the return line unused here. Each word is routed by its two top bits to one of three registers: the left channel level, the right channel level or the operating-mode register. The block then presents the control bits that the converter datapath uses: the two 14-bit levels, mute, power-down, interface format, de-emphasis, the oversampling ratio and the word length used for right-justified input.

The mute, power-down, format, de-emphasis and ratio controls also have board pins. Each effective bit is the OR of its pin and its register bit, so a pin held high always wins over the register. The serial inputs are asynchronous to the block clock. They pass through a two-stage synchronizer and are oversampled, so the serial clock must run well below the block clock.

Top module: `dac_ctrl_port`

## Requirements
- R1: A word is 16 bits, taken MSB first on each rising serial clock while select is low. Bits 15:14 form the target address and bits 13:0 the payload. A completed word reaches the registers three block-clock edges after select is driven high.
- R2: Address 00 loads the payload into the left level (`vol_left`). Address 01 loads it into the right level (`vol_right`).
- R3: Address 10 loads the mode register. Its payload fields are: bit 0 mute, bit 1 power-down, bits 3:2 interface format {fmt1, fmt0}, bit 4 de-emphasis, bits 6:5 oversampling code and bits 8:7 word-length code. Bits 13:9 are ignored.
- R4: A word with address 11 changes no register and no output.
- R5: A word is stored only when exactly 16 rising serial clocks occur between select going low and select going high. With 15 or with 17 clocks the word is dropped and every output stays as it was.
- R6: The effective mute, power-down, interface format (00 right-justified, 01 I2S, 10 left-justified, 11 DSP word-sync) and de-emphasis outputs are registered each block clock as the pin OR the register bit.
- R7: The oversampling code is the pin OR the register value: 00 selects 8x, 01 selects 4x and 10 selects 2x. When this combined code is 11, `eff_interp` keeps its last legal value and `interp_err` is 1. `interp_err` returns to 0 once the combined code is legal again.
- R8: `eff_rj_len` gives the right-justified word length as 0 for 24 bits, 1 for 20 bits and 2 for 16 bits. The register codes are 00 for 24 bits, 01 for 20 bits, 10 for 16 bits, and 11 also gives 24 bits.
- R9: After reset both levels are 0x3FFF (full scale), all mode register fields are zero, all effective outputs are 0 and `interp_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low word select |
| spi_mosi | input | 1 | Serial data from the host |
| pin_mute | input | 1 | Board mute pin |
| pin_pdn | input | 1 | Board power-down pin |
| pin_fmt | input | 2 | Board interface-format pins |
| pin_deemph | input | 1 | Board de-emphasis pin |
| pin_interp | input | 2 | Board oversampling-code pins |
| vol_left | output | 14 | Left channel level |
| vol_right | output | 14 | Right channel level |
| eff_mute | output | 1 | Effective mute |
| eff_pdn | output | 1 | Effective power-down |
| eff_fmt | output | 2 | Effective interface format |
| eff_deemph | output | 1 | Effective de-emphasis |
| eff_interp | output | 2 | Effective oversampling code, always legal |
| interp_err | output | 1 | Combined oversampling code is illegal |
| eff_rj_len | output | 2 | Right-justified word-length selection |

## Verification
Well-formed words are sent to each of the three addresses. The level payloads are chosen with mixed bit patterns, so a reversed shift order or a misplaced field would show up. Malformed transfers with 15 and with 17 clocks, and a word to the unused address, are each sent after a known value has been stored; this separates a correct discard from an accidental write. Pin-high and register-high stimuli are applied one at a time, and the illegal oversampling code is reached once from the register and once from the pin OR-ing with the register. This shows that the value is held rather than passed through.

// File: rtl/dac_ctrl_port.sv
module dac_ctrl_port #(
  parameter int WORD_W = 16,
  parameter int VOL_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  input  logic             pin_mute,
  input  logic             pin_pdn,
  input  logic [1:0]       pin_fmt,
  input  logic             pin_deemph,
  input  logic [1:0]       pin_interp,
  output logic [VOL_W-1:0] vol_left,
  output logic [VOL_W-1:0] vol_right,
  output logic             eff_mute,
  output logic             eff_pdn,
  output logic [1:0]       eff_fmt,
  output logic             eff_deemph,
  output logic [1:0]       eff_interp,
  output logic             interp_err,
  output logic [1:0]       eff_rj_len
);
  localparam int ADDR_W  = WORD_W - VOL_W;
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_SAT = WORD_W + 1;

  logic [2:0] sclk_q, cs_q, mosi_q;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[1:0], spi_cs_n};
      mosi_q <= {mosi_q[1:0], spi_mosi};
    end

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire cs_fall   = ~cs_q[1] & cs_q[2];
  wire cs_rise   = cs_q[1] & ~cs_q[2];
  wire commit    = cs_rise && (bitcnt == CNT_W'(WORD_W));
  wire [ADDR_W-1:0] addr    = shreg[WORD_W-1 -: ADDR_W];
  wire [VOL_W-1:0]  payload = shreg[VOL_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (cs_fall) begin
      bitcnt <= '0;
    end else if (!cs_q[1] && sclk_rise) begin
      shreg <= {shreg[WORD_W-2:0], mosi_q[1]};
      if (bitcnt != CNT_W'(CNT_SAT)) bitcnt <= bitcnt + 1'b1;
    end

  logic       m_mute, m_pdn, m_deemph;
  logic [1:0] m_fmt, m_interp, m_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vol_left  <= '1;
      vol_right <= '1;
      m_mute    <= 1'b0;
      m_pdn     <= 1'b0;
      m_fmt     <= 2'b00;
      m_deemph  <= 1'b0;
      m_interp  <= 2'b00;
      m_len     <= 2'b00;
    end else if (commit) begin
      case (addr)
        2'b00: vol_left  <= payload;
        2'b01: vol_right <= payload;
        2'b10: begin
          m_mute   <= payload[0];
          m_pdn    <= payload[1];
          m_fmt    <= payload[3:2];
          m_deemph <= payload[4];
          m_interp <= payload[6:5];
          m_len    <= payload[8:7];
        end
        default: ;
      endcase
    end

  wire [1:0] interp_or = pin_interp | m_interp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      eff_mute   <= 1'b0;
      eff_pdn    <= 1'b0;
      eff_fmt    <= 2'b00;
      eff_deemph <= 1'b0;
      eff_interp <= 2'b00;
      interp_err <= 1'b0;
      eff_rj_len <= 2'b00;
    end else begin
      eff_mute   <= pin_mute | m_mute;
      eff_pdn    <= pin_pdn | m_pdn;
      eff_fmt    <= pin_fmt | m_fmt;
      eff_deemph <= pin_deemph | m_deemph;
      eff_rj_len <= (m_len == 2'b11) ? 2'b00 : m_len;
      if (interp_or == 2'b11) begin
        interp_err <= 1'b1;
      end else begin
        interp_err <= 1'b0;
        eff_interp <= interp_or;
      end
    end

  p_no_commit_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(vol_left) && $stable(vol_right)));
  p_addr11_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == 2'b11) |=> ($stable(vol_left) && $stable(vol_right)
                                    && $stable(m_interp) && $stable(m_fmt)));
  p_interp_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eff_interp != 2'b11);
  p_interp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (interp_or == 2'b11) |=> (interp_err && $stable(eff_interp)));
  p_pin_mute_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mute |=> eff_mute);
endmodule

// File: tb/test_dac_ctrl_port.sv
module test_dac_ctrl_port;
  logic clk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
  logic pin_mute = 0, pin_pdn = 0, pin_deemph = 0;
  logic [1:0] pin_fmt = 0, pin_interp = 0;
  logic [13:0] vol_left, vol_right;
  logic eff_mute, eff_pdn, eff_deemph, interp_err;
  logic [1:0] eff_fmt, eff_interp, eff_rj_len;

  always #2.5 clk = ~clk;

  dac_ctrl_port i_dac_ctrl_port (.*);

  int checks = 0, errors = 0;
  bit done = 0, model_on = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed { logic sclk, cs_n, mosi; } smp_t;
  smp_t hist[$];
  int   r_cnt;
  logic [15:0] r_sh;
  int   r_vl, r_vr, r_mode;
  int   e_mute, e_pdn, e_fmt, e_de, e_int, e_err, e_len;

  task automatic model_reset();
    hist = {};
    repeat (4) hist.push_back('{sclk:1'b0, cs_n:1'b1, mosi:1'b0});
    r_cnt = 0; r_sh = 0; r_vl = 'h3FFF; r_vr = 'h3FFF; r_mode = 0;
    e_mute = 0; e_pdn = 0; e_fmt = 0; e_de = 0; e_int = 0; e_err = 0; e_len = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int comb, ml;
      smp_t a, b;
      hist.push_front('{sclk:spi_sclk, cs_n:spi_cs_n, mosi:spi_mosi});
      void'(hist.pop_back());
      a = hist[2]; b = hist[3];
      e_mute = pin_mute | (r_mode & 1);
      e_pdn  = pin_pdn | ((r_mode >> 1) & 1);
      e_fmt  = pin_fmt | ((r_mode >> 2) & 3);
      e_de   = pin_deemph | ((r_mode >> 4) & 1);
      ml = (r_mode >> 7) & 3;
      e_len = (ml == 3) ? 0 : ml;
      comb = pin_interp | ((r_mode >> 5) & 3);
      if (comb == 3) e_err = 1; else begin e_err = 0; e_int = comb; end
      if (!a.cs_n && b.cs_n) r_cnt = 0;
      else if (!a.cs_n && a.sclk && !b.sclk) begin
        r_sh = {r_sh[14:0], a.mosi};
        r_cnt++;
      end
      if (a.cs_n && !b.cs_n && r_cnt == 16) begin
        case (r_sh[15:14])
          2'b00: r_vl = r_sh[13:0];
          2'b01: r_vr = r_sh[13:0];
          2'b10: r_mode = r_sh[13:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) if (model_on && rst_n) begin
    chk("R2 vol_left", vol_left, r_vl);
    chk("R2 vol_right", vol_right, r_vr);
    chk("R6 eff_mute", eff_mute, e_mute);
    chk("R6 eff_pdn", eff_pdn, e_pdn);
    chk("R6 eff_fmt", eff_fmt, e_fmt);
    chk("R6 eff_deemph", eff_deemph, e_de);
    chk("R7 eff_interp", eff_interp, e_int);
    chk("R7 interp_err", interp_err, e_err);
    chk("R8 eff_rj_len", eff_rj_len, e_len);
  end

  task automatic xfer(input logic [15:0] w, input int nclk);
    spi_cs_n = 0; repeat (4) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      spi_mosi = w[15 - (i % 16)];
      spi_sclk = 0; repeat (4) @(negedge clk);
      spi_sclk = 1; repeat (4) @(negedge clk);
    end
    spi_sclk = 0; repeat (4) @(negedge clk);
    spi_cs_n = 1; repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1; model_on = 1;
    @(negedge clk);
    chk("R9 reset vol_left", vol_left, 'h3FFF);
    chk("R9 reset vol_right", vol_right, 'h3FFF);
    chk("R9 reset interp_err", interp_err, 0);
    xfer({2'b00, 14'h1234}, 16);
    chk("R1 left MSB first", vol_left, 'h1234);
    xfer({2'b01, 14'h0ABC}, 16);
    chk("R2 right level", vol_right, 'h0ABC);
    chk("R2 left untouched", vol_left, 'h1234);
    xfer({2'b11, 14'h3FFF}, 16);
    chk("R4 addr11 left", vol_left, 'h1234);
    chk("R4 addr11 mute", eff_mute, 0);
    xfer({2'b00, 14'h0000}, 15);
    chk("R5 short word dropped", vol_left, 'h1234);
    xfer({2'b00, 14'h0000}, 17);
    chk("R5 long word dropped", vol_left, 'h1234);
    xfer({2'b10, 14'h001}, 16);
    chk("R3 mute bit", eff_mute, 1);
    xfer({2'b10, 14'h01E}, 16);
    chk("R3 pdn bit", eff_pdn, 1);
    chk("R3 fmt field", eff_fmt, 3);
    chk("R3 deemph bit", eff_deemph, 1);
    chk("R3 mute cleared", eff_mute, 0);
    xfer({2'b10, 14'h000}, 16);
    pin_mute = 1; pin_fmt = 2'b10; repeat (3) @(negedge clk);
    chk("R6 pin mute over reg", eff_mute, 1);
    chk("R6 pin fmt", eff_fmt, 2);
    pin_mute = 0; pin_fmt = 0; repeat (3) @(negedge clk);
    chk("R6 pin released", eff_mute, 0);
    xfer({2'b10, 14'h040}, 16);
    chk("R7 interp 2x", eff_interp, 2);
    xfer({2'b10, 14'h060}, 16);
    chk("R7 illegal held", eff_interp, 2);
    chk("R7 err raised", interp_err, 1);
    xfer({2'b10, 14'h020}, 16);
    chk("R7 interp 4x", eff_interp, 1);
    chk("R7 err cleared", interp_err, 0);
    pin_interp = 2'b10; repeat (3) @(negedge clk);
    chk("R7 pin-made illegal held", eff_interp, 1);
    chk("R7 pin-made err", interp_err, 1);
    pin_interp = 0; repeat (3) @(negedge clk);
    xfer({2'b10, 14'h080}, 16);
    chk("R8 len 20", eff_rj_len, 1);
    xfer({2'b10, 14'h100}, 16);
    chk("R8 len 16", eff_rj_len, 2);
    xfer({2'b10, 14'h180}, 16);
    chk("R8 code 11 gives 24", eff_rj_len, 0);
    @(negedge clk); rst_n = 0; model_on = 0;
    @(negedge clk);
    chk("R9 reset after writes", vol_left, 'h3FFF);
    chk("R9 reset interp", eff_interp, 0);
    rst_n = 1; model_on = 1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule